// File: doc/BRIEF.md
# Bus-Mapped Single-Bit Output Port

This block is a write-only, one-bit output port that sits beside an 8-bit microprocessor bus with a 16-bit address. It watches the address lines, the read/not-write line, the phase-2 bus clock and the data byte. It holds one bit in a register that can drive an indicator such as an LED. The port is mapped into a 16 KB window: only address bits 15 and 14 are decoded, so any address from 0x4000 to 0x7FFF reaches it. A bus cycle updates the stored bit only if it is a write into that window. Every other cycle leaves the bit alone, including instruction fetches and reset-vector reads.

The block does not gate a clock. All bus inputs are re-timed into a fast system clock through multi-flop synchronizers. A write is accepted when the synchronized phase-2 signal shows a rising edge and the synchronized decode and write conditions hold in that same cycle. Each accepted write also raises a strobe output for one system-clock cycle, so surrounding logic can count accepted writes. The system clock must be at least four times faster than phase 2. The address, read/not-write line and data must be stable from before the phase-2 rising edge until at least two system-clock cycles after it.

Top module: `busbit_port`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `led_out` and `wr_pulse` become 0 on that edge.
- R2: A write is accepted only when address bit 15 is 0, address bit 14 is 1, `bus_rnw` is 0 (write) and `bus_phi2` rises. This condition equals (bit15 NOR rnw) AND bit14, gated by the phase-2 edge.
- R3: A write to any address from 0x4000 through 0x7FFF loads `led_out` from the data byte. Address bits 13 to 0 do not matter, so 0x4002 behaves the same as 0x4000.
- R4: A cycle with `bus_rnw` = 1 (read) never changes `led_out`, whatever its address. This includes 0x8000-range fetches and 0xFFFC/0xFFFD.
- R5: A write whose address has bit 15 = 1 or bit 14 = 0 leaves `led_out` unchanged.
- R6: Only data bit 0 is stored. Bits 7 to 1 have no effect on `led_out`.
- R7: The capture is edge-triggered. If the data changes while `bus_phi2` stays high after an accepted edge, `led_out` does not change.
- R8: `wr_pulse` is high for exactly one `clk` cycle per accepted write and is never high otherwise.
- R9: `led_out` takes its new value on the third rising `clk` edge that samples `bus_phi2` high. It still holds the old value after the second such edge.
- R10: Writes of 0xFF, then 0x02, then 0x05 into the window, with reads in between, drive `led_out` to 1, then 0, then 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock, at least 4x the phase-2 rate |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Processor address bus |
| bus_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_phi2 | input | 1 | Processor phase-2 clock |
| bus_data | input | 8 | Processor data bus |
| led_out | output | 1 | Stored port bit |
| wr_pulse | output | 1 | One-cycle strobe per accepted write |

## Verification
The main sweep walks all sixteen values of the top address nibble against both read and write cycles. It uses scattered low address bits, and each data byte has its bit 0 set opposite to the current port value. Any wrongly accepted or wrongly rejected cycle therefore shows up as a visible flip or a missing flip, and as a wrong strobe count. Separate patterns cover four cases: toggling only the upper data bits, changing data while phase 2 stays high, counting the exact edge of the update, and replaying a short program trace of fetches, vector reads and three window writes.

// File: rtl/busbit_pkg.sv
// Package: shared defaults and the bundle of single-bit bus controls that
// travel through the synchronizer together.
package busbit_pkg;

    localparam int unsigned BB_ADDR_W   = 16;
    localparam int unsigned BB_DATA_W   = 8;
    localparam int unsigned BB_STAGES   = 2;

    // Control bits re-timed alongside the address.
    typedef struct packed {
        logic phi2;   // processor phase-2 clock
        logic rnw;    // 1 = read, 0 = write
        logic dbit;   // selected data line
    } bus_ctl_t;

    localparam int unsigned BB_CTL_W = $bits(bus_ctl_t);

endpackage

// File: rtl/busbit_sync.sv
// Module: busbit_sync
// Multi-stage synchronizer for a vector of asynchronous bus signals.
// Assumes: STAGES >= 2; the inputs are quasi-static around the sampling
// point (bus held stable by the protocol), so bits arriving together stay
// together after synchronization.
module busbit_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_q;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[STAGES-2:0], din};
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/busbit_decode.sv
// Module: busbit_decode
// Address window and write qualification on synchronized bus signals.
// Assumes: the window is selected by masked address compare; only the
// masked bits matter, so the port repeats across the unmasked range.
module busbit_decode #(
    parameter int unsigned            ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]      DEC_MASK  = 16'hC000,
    parameter logic [ADDR_W-1:0]      DEC_MATCH = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic              rnw_s,
    output logic              wr_hit
);

    logic win_hit;

    // Window match on masked address bits.
    always_comb begin
        win_hit = ((addr_s & DEC_MASK) == DEC_MATCH);
    end

    // Qualify with a write cycle.
    always_comb begin
        wr_hit = win_hit & ~rnw_s;
    end

    // For the default two-bit window, cross-check against the NOR form.
    generate
        if (ADDR_W == 16 && DEC_MASK == 16'hC000 && DEC_MATCH == 16'h4000) begin : g_nor_check
            AST_NOR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit == (~(addr_s[15] | rnw_s) & addr_s[14])); // R2
        end
    endgenerate

endmodule

// File: rtl/busbit_capture.sv
// Module: busbit_capture
// Detects the rising phase-2 edge on the synchronized strobe and loads the
// port bit when the cycle is a qualified write; emits a one-cycle pulse.
// Assumes: wr_hit and dbit are valid in the cycle the edge is seen.
module busbit_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2_s,
    input  logic wr_hit,
    input  logic dbit,
    output logic led_q,
    output logic pulse_q
);

    logic phi2_d;
    logic phi2_rise;
    logic take;

    // Remember the previous synchronized strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) phi2_d <= 1'b0;
        else        phi2_d <= phi2_s;
    end

    // Edge detect and qualification.
    always_comb begin
        phi2_rise = phi2_s & ~phi2_d;
        take      = phi2_rise & wr_hit;
    end

    // Port register and accepted-write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= take;
            if (take) led_q <= dbit;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!led_q && !pulse_q)); // R1
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R8
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_q |-> $stable(led_q)); // R4

endmodule

// File: rtl/busbit_port.sv
// Module: busbit_port (top)
// Write-only single-bit output port for an 8-bit processor bus. Re-times
// the bus into the system clock, decodes the address window and captures
// one data line on the rising phase-2 edge of a qualified write.
// Assumes: clk >= 4x phi2; address/rnw/data stable from before phi2 rises
// until at least STAGES clk cycles after.
module busbit_port
    import busbit_pkg::*;
#(
    parameter int unsigned            ADDR_W      = BB_ADDR_W,
    parameter int unsigned            DATA_W      = BB_DATA_W,
    parameter int unsigned            STAGES      = BB_STAGES,
    parameter int unsigned            CAPTURE_BIT = 0,
    parameter logic [ADDR_W-1:0]      DEC_MASK    = 16'hC000,
    parameter logic [ADDR_W-1:0]      DEC_MATCH   = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rnw,
    input  logic              bus_phi2,
    input  logic [DATA_W-1:0] bus_data,
    output logic              led_out,
    output logic              wr_pulse
);

    localparam logic [DATA_W-1:0] DSEL = DATA_W'(1) << CAPTURE_BIT;
    localparam int unsigned       SYNC_W = ADDR_W + BB_CTL_W;

    bus_ctl_t          ctl_raw;
    bus_ctl_t          ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic              hit;

    // Bundle the single-bit controls; pick the captured data line by mask.
    always_comb begin
        ctl_raw.phi2 = bus_phi2;
        ctl_raw.rnw  = bus_rnw;
        ctl_raw.dbit = |(bus_data & DSEL);
    end

    busbit_sync #(
        .W      (SYNC_W),
        .STAGES (STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({bus_addr, ctl_raw}),
        .dout  ({addr_s, ctl_s})
    );

    busbit_decode #(
        .ADDR_W    (ADDR_W),
        .DEC_MASK  (DEC_MASK),
        .DEC_MATCH (DEC_MATCH)
    ) decode_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_s (addr_s),
        .rnw_s  (ctl_s.rnw),
        .wr_hit (hit)
    );

    busbit_capture capture_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phi2_s  (ctl_s.phi2),
        .wr_hit  (hit),
        .dbit    (ctl_s.dbit),
        .led_q   (led_out),
        .pulse_q (wr_pulse)
    );

    AST_CAPTURE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> (led_out == $past(ctl_s.dbit))); // R6
    AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(hit)); // R3
    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> ($past(ctl_s.phi2) && !$past(ctl_s.phi2, 2))); // R7

endmodule

// File: tb/busbit_port_tb.sv
// Bench for busbit_port: sweeps address nibble x read/write with a
// bench-side model of the port bit, plus directed edge and latency cases.
module busbit_port_tb_top;

    localparam int unsigned CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic        bus_rnw;
    logic        bus_phi2;
    logic [7:0]  bus_data;
    logic        led_out;
    logic        wr_pulse;

    int n_chk  = 0;
    int n_bad  = 0;
    int pulses = 0;
    logic exp_led = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busbit_port dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rnw  (bus_rnw),
        .bus_phi2 (bus_phi2),
        .bus_data (bus_data),
        .led_out  (led_out),
        .wr_pulse (wr_pulse)
    );

    // Count accepted-write strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && wr_pulse === 1'b1) pulses++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // One full bus cycle: setup, phi2 high for 4 clks, hold after fall.
    task automatic bus_cycle(input logic [15:0] a, input logic r, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rnw = r; bus_data = d; bus_phi2 = 1'b0;
        repeat (3) @(negedge clk);
        bus_phi2 = 1'b1;
        repeat (4) @(negedge clk);
        bus_phi2 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Run a cycle and compare port bit and strobe count with the model.
    task automatic run_check(input logic [15:0] a, input logic r, input logic [7:0] d,
                             input string tag);
        int p0;
        logic acc;
        p0  = pulses;
        acc = (a[15:14] == 2'b01) && !r;
        bus_cycle(a, r, d);
        if (acc) exp_led = d[0];
        chk(tag, int'(led_out), int'(exp_led));
        chk({tag, "/R8 pulse count"}, pulses - p0, int'(acc));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    initial begin
        rst_n = 1'b0; bus_addr = 16'h4000; bus_rnw = 1'b0; bus_data = 8'hFF; bus_phi2 = 1'b0;
        // R1: reset holds outputs low even with a qualified write pattern
        repeat (2) @(negedge clk);
        bus_phi2 = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 led in reset", int'(led_out), 0);
        chk("R1 pulse in reset", int'(wr_pulse), 0);
        bus_phi2 = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 led after reset", int'(led_out), 0);

        // R10: program trace with vector reads and fetches
        run_check(16'hFFFC, 1'b1, 8'h00, "R10 vec lo");
        run_check(16'hFFFD, 1'b1, 8'h81, "R10 vec hi");
        run_check(16'h8000, 1'b1, 8'hA9, "R10 fetch");
        run_check(16'h8001, 1'b1, 8'hFF, "R10 operand");
        run_check(16'h4002, 1'b0, 8'hFF, "R10 write FF");
        chk("R10 first", int'(led_out), 1);
        run_check(16'h8005, 1'b1, 8'hA9, "R10 fetch");
        run_check(16'h4000, 1'b0, 8'h02, "R10 write 02");
        chk("R10 second", int'(led_out), 0);
        run_check(16'h800B, 1'b1, 8'h05, "R10 operand");
        run_check(16'h4000, 1'b0, 8'h05, "R10 write 05");
        chk("R10 third", int'(led_out), 1);

        // R6: upper data bits alone never move the port
        run_check(16'h5000, 1'b0, 8'hFE, "R6 upper ones D0=0");
        run_check(16'h6123, 1'b0, 8'h01, "R6 upper zeros D0=1");
        run_check(16'h7FFF, 1'b0, 8'hFF, "R6 all ones");

        // R7: data changes while phi2 stays high after the edge
        @(negedge clk);
        bus_addr = 16'h4000; bus_rnw = 1'b0; bus_data = 8'h00;
        repeat (3) @(negedge clk);
        bus_phi2 = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 captured 0", int'(led_out), 0);
        bus_data = 8'h01;
        repeat (6) @(negedge clk);
        chk("R7 held while high", int'(led_out), 0);
        bus_phi2 = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 held after fall", int'(led_out), 0);
        exp_led = 1'b0;

        // R9: update lands on the third edge that samples phi2 high
        @(negedge clk);
        bus_data = 8'h01;
        repeat (3) @(negedge clk);
        bus_phi2 = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 old after 2 edges", int'(led_out), 0);
        chk("R9 no pulse yet", int'(wr_pulse), 0);
        @(posedge clk); @(negedge clk);
        chk("R9 new after 3 edges", int'(led_out), 1);
        chk("R9/R8 pulse on update", int'(wr_pulse), 1);
        @(negedge clk);
        chk("R8 pulse one cycle", int'(wr_pulse), 0);
        bus_phi2 = 1'b0;
        repeat (3) @(negedge clk);
        exp_led = 1'b1;

        // R2-R5 sweep: top nibble x read/write, D0 opposite to the model
        for (int hi = 0; hi < 16; hi++) begin
            for (int r = 0; r < 2; r++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [15:0] a;
                    logic [7:0]  d;
                    string       tag;
                    a = {4'(hi), 12'(hi * 291 + k * 1365)};
                    d = 8'(hi * 53 + k * 101 + r * 7);
                    d[0] = ~exp_led;
                    if (r == 1)                 tag = "R4 read ignored";
                    else if (a[15:14] == 2'b01) tag = "R3/R2 window write";
                    else                        tag = "R5 outside write";
                    run_check(a, 1'(r), d, tag);
                end
            end
        end

        // R1: mid-run reset clears a set port
        run_check(16'h4000, 1'b0, 8'h01, "R3 set before reset");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid-run clear", int'(led_out), 0);
        rst_n = 1'b1;
        exp_led = 1'b0;
        run_check(16'hC000, 1'b0, 8'h01, "R5 after reset");

        wrap_up();
    end

endmodule